// File: doc/BRIEF.md
# One-Tap Loop-Unrolled DFE Slicer

This block turns a stream of signed receiver samples into bit decisions while cancelling the first post-cursor intersymbol interference. It does not subtract the tap from the sample inside the feedback loop. Instead it slices every sample against two thresholds at once. The upper threshold, +h1, is the candidate for a previous decision of one. The lower threshold, -h1, is the candidate for a previous decision of zero. The decision already held in the register then picks one candidate. The only feedback path is that register and one 2:1 multiplexer.

One sample is accepted per unit interval while the valid strobe is high. The tap weight h1 is a signed value that can be changed at run time. The decision and a matching valid appear one cycle after the sample. Two debug outputs show the registered result of each speculative comparison. A parameter can tie these debug outputs to zero. Only the first tap is unrolled, because each further tap would double the number of comparators.

Top module: `dfe1_unrolled_slicer`

## Requirements
- R1: After reset, valid_o, decision_o, cand_hi_o and cand_lo_o are all 0. The stored previous decision is 0.
- R2: When the stored previous decision is 1, a valid sample gives decision_o = 1 exactly when sample_i > h1_i. Both values are read as 8-bit two's complement.
- R3: When the stored previous decision is 0, a valid sample gives decision_o = 1 exactly when sample_i > -h1_i.
- R4: The comparison is strict. A sample equal to the selected threshold gives a decision of 0.
- R5: valid_o equals valid_i delayed by one clock cycle. The decision for a sample shows on decision_o in the cycle that valid_o is high for that sample.
- R6: While valid_i is low, decision_o, cand_hi_o, cand_lo_o and the stored previous decision all hold their values.
- R7: On each valid sample, cand_hi_o is loaded with (sample_i > h1_i) and cand_lo_o with (sample_i > -h1_i). Both are loaded whatever the previous decision is.
- R8: A change of h1_i while valid_i is low leaves decision_o unchanged. The new h1_i is used for the next valid sample.
- R9: The lower threshold is formed without overflow. With h1_i = -128 it is +128, so the lower candidate is always 0 and the upper candidate is 1 for every sample except -128.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, one unit interval per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Sample strobe |
| sample_i | input | 8 | Signed receiver sample |
| h1_i | input | 8 | Signed first post-cursor tap weight |
| valid_o | output | 1 | Decision valid, one cycle after valid_i |
| decision_o | output | 1 | Registered bit decision, also the previous decision for the next sample |
| cand_hi_o | output | 1 | Debug: registered result against +h1 |
| cand_lo_o | output | 1 | Debug: registered result against -h1 |

## Verification
The assertions take sample_i and h1_i as settled, known values in every cycle where valid_i is high. They take valid_i as low throughout reset. Most properties use $past to rebuild the comparison for the sample of the previous cycle. Those properties therefore assume that no cycle between reset release and the first strobe carries stale inputs. The stimulus changes its inputs only on the falling clock edge and holds valid_i low during reset. It also sweeps every pair of sample and tap value, so the inputs always stay in the defined range.

// File: rtl/dfe_pkg.sv
package dfe_pkg;
  typedef enum logic {
    EYE_LO = 1'b0,
    EYE_HI = 1'b1
  } eye_e;

  localparam int unsigned NUM_EYES = 2;

  function automatic int unsigned cmp_width(input int unsigned sw, input int unsigned tw);
    return ((sw > tw) ? sw : tw) + 1;
  endfunction
endpackage

// File: rtl/dfe_thresh.sv
module dfe_thresh #(
  parameter int unsigned TW = 8,
  parameter int unsigned CW = 9
) (
  input  logic [TW-1:0]        h1_i,
  output logic signed [CW-1:0] thr_hi_o,
  output logic signed [CW-1:0] thr_lo_o
);
  logic signed [CW-1:0] h1_x;

  // widened before negation so that -(most negative) is representable
  assign h1_x     = {{(CW-TW){h1_i[TW-1]}}, h1_i};
  assign thr_hi_o = h1_x;
  assign thr_lo_o = -h1_x;
endmodule

// File: rtl/dfe_slicer.sv
module dfe_slicer #(
  parameter int unsigned SW = 8,
  parameter int unsigned CW = 9
) (
  input  logic [SW-1:0]        sample_i,
  input  logic signed [CW-1:0] thr_i,
  output logic                 bit_o
);
  logic signed [CW-1:0] s_x;

  assign s_x   = {{(CW-SW){sample_i[SW-1]}}, sample_i};
  assign bit_o = (s_x > thr_i);
endmodule

// File: rtl/dfe_select.sv
module dfe_select (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic cand_hi_i,
  input  logic cand_lo_i,
  output logic valid_o,
  output logic dec_o,
  output logic cand_hi_o,
  output logic cand_lo_o
);
  import dfe_pkg::*;

  eye_e sel;
  logic dec_q, dec_d;
  logic hi_q, lo_q, vld_q;

  // loop: dec_q -> mux -> dec_q
  assign sel   = eye_e'(dec_q);
  assign dec_d = (sel == EYE_HI) ? cand_hi_i : cand_lo_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q <= 1'b0;
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) begin
        dec_q <= dec_d;
        hi_q  <= cand_hi_i;
        lo_q  <= cand_lo_i;
      end
    end
  end

  assign valid_o   = vld_q;
  assign dec_o     = dec_q;
  assign cand_hi_o = hi_q;
  assign cand_lo_o = lo_q;
endmodule

// File: rtl/dfe1_unrolled_slicer.sv
module dfe1_unrolled_slicer #(
  parameter int unsigned SW       = 8,
  parameter int unsigned TW       = 8,
  parameter bit          DEBUG_EN = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [SW-1:0] sample_i,
  input  logic [TW-1:0] h1_i,
  output logic          valid_o,
  output logic          decision_o,
  output logic          cand_hi_o,
  output logic          cand_lo_o
);
  import dfe_pkg::*;

  localparam int unsigned CW = cmp_width(SW, TW);

  logic signed [CW-1:0] thr [NUM_EYES];
  logic [NUM_EYES-1:0]  cand;
  logic                 hi_r, lo_r;

  dfe_thresh #(.TW(TW), .CW(CW)) u_thresh (
    .h1_i     (h1_i),
    .thr_hi_o (thr[EYE_HI]),
    .thr_lo_o (thr[EYE_LO])
  );

  for (genvar e = 0; e < NUM_EYES; e++) begin : g_eye
    dfe_slicer #(.SW(SW), .CW(CW)) u_slicer (
      .sample_i (sample_i),
      .thr_i    (thr[e]),
      .bit_o    (cand[e])
    );
  end

  dfe_select u_select (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .cand_hi_i (cand[EYE_HI]),
    .cand_lo_i (cand[EYE_LO]),
    .valid_o   (valid_o),
    .dec_o     (decision_o),
    .cand_hi_o (hi_r),
    .cand_lo_o (lo_r)
  );

  if (DEBUG_EN) begin : g_dbg
    assign cand_hi_o = hi_r;
    assign cand_lo_o = lo_r;
  end else begin : g_nodbg
    assign cand_hi_o = 1'b0;
    assign cand_lo_o = 1'b0;
  end
endmodule

// File: rtl/dfe1_unrolled_slicer_chk.sv
module dfe1_unrolled_slicer_chk #(
  parameter int unsigned SW = 8,
  parameter int unsigned TW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [SW-1:0] sample_i,
  input logic [TW-1:0] h1_i,
  input logic          valid_o,
  input logic          decision_o,
  input logic          cand_hi_o,
  input logic          cand_lo_o
);
  localparam int unsigned CW = ((SW > TW) ? SW : TW) + 2;

  logic signed [CW-1:0] s_w, h_w, hn_w;
  logic gt_hi, gt_lo;

  assign s_w   = CW'($signed(sample_i));
  assign h_w   = CW'($signed(h1_i));
  assign hn_w  = 0 - h_w;
  assign gt_hi = s_w > h_w;
  assign gt_lo = s_w > hn_w;

  assert_valid_delay_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(decision_o) && $stable(cand_hi_o) && $stable(cand_lo_o)));
  assert_prev_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && decision_o) |=> (decision_o == $past(gt_hi)));
  assert_prev_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !decision_o) |=> (decision_o == $past(gt_lo)));
  assert_cands_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (cand_hi_o == $past(gt_hi) && cand_lo_o == $past(gt_lo)));
  assert_min_tap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && h1_i == {1'b1, {(TW-1){1'b0}}}) |=> !cand_lo_o);
endmodule

bind dfe1_unrolled_slicer dfe1_unrolled_slicer_chk #(.SW(SW), .TW(TW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .sample_i   (sample_i),
  .h1_i       (h1_i),
  .valid_o    (valid_o),
  .decision_o (decision_o),
  .cand_hi_o  (cand_hi_o),
  .cand_lo_o  (cand_lo_o)
);

// File: tb/dfe1_unrolled_slicer_tb.sv
`timescale 1ns/1ps
module dfe1_unrolled_slicer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] sample_i = '0;
  logic [7:0] h1_i = '0;
  logic       valid_o, decision_o, cand_hi_o, cand_lo_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit exp_prev = 1'b0;

  always #2 clk = ~clk;

  dfe1_unrolled_slicer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .sample_i(sample_i), .h1_i(h1_i),
    .valid_o(valid_o), .decision_o(decision_o), .cand_hi_o(cand_hi_o), .cand_lo_o(cand_lo_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive at negedge, sample 1 ns after the following posedge
  task automatic step(input bit v, input logic [7:0] s, input logic [7:0] h, input bit chk_all);
    int si, hi;
    bit e_hi, e_lo, e_dec, old_dec;
    old_dec = decision_o;
    valid_i = v; sample_i = s; h1_i = h;
    si = $signed(s); hi = $signed(h);
    e_hi = si > hi;
    e_lo = si > -hi;
    @(posedge clk); #1;
    check(valid_o == v, "R5 valid_o", int'(valid_o), int'(v));
    if (v) begin
      e_dec = exp_prev ? e_hi : e_lo;
      if (chk_all) begin
        check(decision_o == e_dec, exp_prev ? "R2 decision" : "R3 decision",
              int'(decision_o), int'(e_dec));
        check(cand_hi_o == e_hi, "R7 cand_hi", int'(cand_hi_o), int'(e_hi));
        check(cand_lo_o == e_lo, "R7 cand_lo", int'(cand_lo_o), int'(e_lo));
        if ((exp_prev && si == hi) || (!exp_prev && si == -hi))
          check(decision_o == 1'b0, "R4 equal threshold", int'(decision_o), 0);
      end
      exp_prev = e_dec;
    end else begin
      check(decision_o == old_dec, "R6 hold", int'(decision_o), int'(old_dec));
    end
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++;
        $display("FAIL R5 watchdog actual=%0d expected=%0d", cycles, 190000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(valid_o == 0 && decision_o == 0 && cand_hi_o == 0 && cand_lo_o == 0,
          "R1 reset outputs", {valid_o, decision_o, cand_hi_o, cand_lo_o}, 0);
    // R3: previous decision 0 after reset: 5 > -3
    step(1'b1, 8'd5, 8'd3, 1'b1);
    check(decision_o == 1'b1, "R3 first after reset", int'(decision_o), 1);
    // R4 boundary: prev 1, sample == +h1
    step(1'b1, 8'd3, 8'd3, 1'b1);
    check(decision_o == 1'b0, "R4 upper equal", int'(decision_o), 0);
    // R4 boundary: prev 0, sample == -h1
    step(1'b1, 8'hFD, 8'd3, 1'b1);
    check(decision_o == 1'b0, "R4 lower equal", int'(decision_o), 0);
    // R6 idle with changing sample
    step(1'b1, 8'd100, 8'd10, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b0, 8'(8'h80 + i), 8'd10, 1'b1);
    check(decision_o == 1'b1 && cand_hi_o == 1'b1 && cand_lo_o == 1'b1,
          "R6 idle hold", {decision_o, cand_hi_o, cand_lo_o}, 7);
    // R8: change h1 while idle, decision must not move, then take effect
    step(1'b0, 8'd20, 8'd50, 1'b1);
    check(decision_o == 1'b1, "R8 h1 change no disturb", int'(decision_o), 1);
    step(1'b1, 8'd20, 8'd50, 1'b1);
    check(decision_o == 1'b0, "R8 new h1 used", int'(decision_o), 0);
    // R9: h1 = -128, prev 0, sample 127 must give 0
    step(1'b1, 8'd127, 8'h80, 1'b1);
    check(decision_o == 1'b0 && cand_lo_o == 1'b0 && cand_hi_o == 1'b1,
          "R9 min tap", {decision_o, cand_hi_o, cand_lo_o}, 2);
    step(1'b1, 8'h80, 8'h80, 1'b1);
    check(cand_hi_o == 1'b0, "R9 min tap min sample", int'(cand_hi_o), 0);
    // exhaustive sweep of tap x sample, back-to-back valid
    for (int h = 0; h < 256; h++) begin
      for (int s = 0; s < 256; s++) begin
        step(1'b1, 8'(s), 8'(h), 1'b1);
      end
      step(1'b0, 8'h00, 8'(h), 1'b1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule